// File: doc/BRIEF.md
# I/Q Quadrature Fourier Accumulator

This block correlates a signal stream against a pair of reference streams and keeps four running integrals. All the streams are interleaved I/Q samples that repeat in the order I, Q, -I, -Q. The second reference input lags the first by 90 degrees. On every cycle the signal sample is multiplied by both references. A 2-bit phase counter sorts each product into an I-paired or a Q-paired integral. This yields four integrals: direct-by-I, direct-by-Q, shifted-by-I and shifted-by-Q.

The step enable advances the phase counter. The accumulate enable adds the products, but only in cycles where the step enable is also high. The integrals grow for as long as accumulation continues. They restart only on reset.

Each integral is held with extra guard bits at the top and hidden fraction bits at the bottom. The output shows the upper field of each integral. The four fields are packed into one vector.

Top module: `iq_fourier_acc`

## Requirements
- R1: A synchronous active-low reset clears all four integrals to zero. It also sets the phase counter to phase 0 (I), so the first enabled sample after reset goes to the I-paired integrals.
- R2: The phase counter advances by one, modulo 4, on every clock where `step_en` is 1, and holds otherwise. In phases 0 and 2 the products go to the I-paired integrals. In phases 1 and 3 they go to the Q-paired integrals.
- R3: When `acc_en` is 1 and `step_en` is 0, the integrals do not change and the phase counter does not advance.
- R4: When `step_en` is 1 and `acc_en` is 0, the phase counter advances but no integral changes.
- R5: The direct integrals add the signed product `ref_dir * sig_in`. The shifted integrals add the signed product `ref_quad * sig_in`. All three inputs are two's complement, and no sign correction is applied in the negated phases.
- R6: Let the shift be REF_W+SIG_W+GUARD_W-OUT_W-FRAC_W, which is 17 by default. Each product is arithmetically shifted right by that amount, rounding toward minus infinity. It is then added, wrapping modulo 2^(OUT_W+FRAC_W), into an integral of OUT_W+FRAC_W bits. Each output field is that integral with its FRAC_W low bits removed.
- R7: Starting from bit 0, the output fields are direct-I, direct-Q, shifted-I and shifted-Q, each OUT_W bits wide.
- R8: An enabled accumulation is visible on `integrals` right after the clock edge that samples it. Accumulations in back-to-back cycles, with no gap, are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advances the stream phase |
| acc_en | input | 1 | Adds the products; only takes effect when step_en is also 1 |
| ref_dir | input | REF_W | Direct reference sample, signed |
| ref_quad | input | REF_W | Reference sample lagging by 90 degrees, signed |
| sig_in | input | SIG_W | Signal sample, signed |
| integrals | output | 4*OUT_W | Four integral fields, direct-I at the least significant end |

## Verification
The hardest situation to reach is a wrap of an integral in the hidden guard range while the phase counter is out of step with a plain I/Q grouping. The phase is only visible through the field that changes. The stimulus therefore mixes random step-only cycles with pairs of accumulate cycles, so every phase is hit with accumulation both on and off. Directed runs of extreme negative-by-negative products drive the 16-bit integral through its wrap. A single-LSB negative product checks the floor rounding of the shift.

// File: rtl/iq_fourier_pkg.sv
// Package iq_fourier_pkg
// Shared phase type and width arithmetic for the quadrature accumulator.
// Assumes all widths are positive and the product is at least as wide as
// the visible field plus the hidden fraction bits, minus the guard bits.
package iq_fourier_pkg;

    typedef enum logic [1:0] {
        PH_POS_I = 2'd0,
        PH_POS_Q = 2'd1,
        PH_NEG_I = 2'd2,
        PH_NEG_Q = 2'd3
    } phase_e;

    // Right shift applied to each raw product before accumulation.
    function automatic int product_shift(input int ref_w, input int sig_w,
                                         input int guard_w, input int out_w,
                                         input int frac_w);
        return ref_w + sig_w + guard_w - out_w - frac_w;
    endfunction

endpackage

// File: rtl/iq_phase_ctr.sv
// Module iq_phase_ctr
// Tracks the position inside the I, Q, -I, -Q group.
// Assumes the stream source holds step_en high for whole groups of four.
module iq_phase_ctr
    import iq_fourier_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    output phase_e phase
);

    // Advance the phase modulo four on each step, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_POS_I;
        else if (step_en)
            phase <= phase_e'(phase + 2'd1);
    end

endmodule

// File: rtl/iq_prod_scale.sv
// Module iq_prod_scale
// Signed multiply of a reference sample by the signal sample, followed by
// a floor (arithmetic) right shift into the accumulator width.
// Assumes SHIFT >= 0 and ACC_W == REF_W+SIG_W+GUARD_W-SHIFT.
module iq_prod_scale #(
    parameter int REF_W   = 11,
    parameter int SIG_W   = 16,
    parameter int GUARD_W = 6,
    parameter int SHIFT   = 17,
    parameter int ACC_W   = 16
) (
    input  logic [REF_W-1:0]        ref_s,
    input  logic [SIG_W-1:0]        sig_s,
    output logic signed [ACC_W-1:0] scaled
);

    localparam int PROD_W = REF_W + SIG_W;
    localparam int EXT_W  = PROD_W + GUARD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [EXT_W-1:0]  prod_ext;

    // Full-precision signed product.
    always_comb prod = $signed(ref_s) * $signed(sig_s);

    // Sign-extend into the guard bits; a zero-guard build skips the extension.
    generate
        if (GUARD_W > 0) begin : g_guard
            always_comb prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};
        end else begin : g_no_guard
            always_comb prod_ext = prod;
        end
    endgenerate

    // Dropping the low SHIFT bits is a floor division by 2**SHIFT.
    always_comb scaled = prod_ext[EXT_W-1:SHIFT];

endmodule

// File: rtl/iq_integrator.sv
// Module iq_integrator
// One wrapping signed integral; adds the scaled product when add_en is set.
// Assumes the addend already has the accumulator width.
module iq_integrator #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] total
);

    // Integrate modulo 2**ACC_W, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else if (add_en)
            total <= total + addend;
    end

endmodule

// File: rtl/iq_fourier_acc.sv
// Module iq_fourier_acc
// Quadrature Fourier accumulator: multiplies the signal stream by a direct
// and a 90-degree reference, routes each product by stream phase into
// I-paired or Q-paired integrals, and shows the upper part of each.
// Assumes step_en spans whole groups of four samples per integration and
// acc_en is only meaningful together with step_en.
module iq_fourier_acc
    import iq_fourier_pkg::*;
#(
    parameter int REF_W   = 11,
    parameter int SIG_W   = 16,
    parameter int OUT_W   = 13,
    parameter int GUARD_W = 6,
    parameter int FRAC_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               acc_en,
    input  logic [REF_W-1:0]   ref_dir,
    input  logic [REF_W-1:0]   ref_quad,
    input  logic [SIG_W-1:0]   sig_in,
    output logic [4*OUT_W-1:0] integrals
);

    localparam int ACC_W = OUT_W + FRAC_W;
    localparam int SHIFT = product_shift(REF_W, SIG_W, GUARD_W, OUT_W, FRAC_W);
    localparam int N_REF = 2;
    localparam int N_ACC = 2 * N_REF;

    generate
        if (SHIFT < 0) begin : g_bad_widths
            $error("iq_fourier_acc: product narrower than accumulator");
        end
    endgenerate

    phase_e             phase_q;
    logic               acc_go;
    logic [REF_W-1:0]   ref_sel [N_REF];
    logic [ACC_W-1:0]   scaled  [N_REF];
    logic [ACC_W-1:0]   total   [N_ACC];

    // Accumulation happens only on stepped cycles.
    always_comb acc_go = step_en & acc_en;

    // Reference index 0 is direct, 1 is the 90-degree input.
    always_comb begin
        ref_sel[0] = ref_dir;
        ref_sel[1] = ref_quad;
    end

    iq_phase_ctr u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .phase   (phase_q)
    );

    genvar r, k;
    generate
        for (r = 0; r < N_REF; r++) begin : g_ref
            iq_prod_scale #(
                .REF_W   (REF_W),
                .SIG_W   (SIG_W),
                .GUARD_W (GUARD_W),
                .SHIFT   (SHIFT),
                .ACC_W   (ACC_W)
            ) u_scale (
                .ref_s  (ref_sel[r]),
                .sig_s  (sig_in),
                .scaled (scaled[r])
            );
        end

        // Integral k: reference k/2, odd k takes the Q phases.
        for (k = 0; k < N_ACC; k++) begin : g_acc
            logic add_en;

            // Route by the phase LSB: even phases feed I, odd phases feed Q.
            always_comb add_en = acc_go & (phase_q[0] == k[0]);

            iq_integrator #(.ACC_W(ACC_W)) u_int (
                .clk    (clk),
                .rst_n  (rst_n),
                .add_en (add_en),
                .addend (scaled[k / 2]),
                .total  (total[k])
            );

            // Drop the hidden fraction bits on the way out.
            always_comb integrals[k*OUT_W +: OUT_W] = total[k][ACC_W-1:FRAC_W];
        end
    endgenerate

endmodule

// File: rtl/iq_fourier_acc_chk.sv
// Module iq_fourier_acc_chk
// Temporal checks on the accumulator's ports and its phase counter.
// Assumes it is bound into iq_fourier_acc.
module iq_fourier_acc_chk #(
    parameter int OUT_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en,
    input logic               acc_en,
    input logic [1:0]         phase_q,
    input logic [4*OUT_W-1:0] integrals
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (integrals == '0 && phase_q == 2'd0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> phase_q == $past(phase_q) + 2'd1);

    // R3
    acc_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !step_en) |=> ($stable(integrals) && $stable(phase_q)));

    // R4
    step_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !acc_en) |=> $stable(integrals));

    // R2
    i_phase_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && acc_en && !phase_q[0]) |=>
            ($stable(integrals[2*OUT_W-1:OUT_W]) && $stable(integrals[4*OUT_W-1:3*OUT_W])));

    // R2
    q_phase_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && acc_en && phase_q[0]) |=>
            ($stable(integrals[OUT_W-1:0]) && $stable(integrals[3*OUT_W-1:2*OUT_W])));

endmodule

bind iq_fourier_acc iq_fourier_acc_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .acc_en    (acc_en),
    .phase_q   (phase_q),
    .integrals (integrals)
);

// File: tb/sim_iq_fourier_acc.sv
module sim_iq_fourier_acc;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int REF_W = 11, SIG_W = 16, OUT_W = 13, GUARD_W = 6, FRAC_W = 3;
    localparam int ACC_W = OUT_W + FRAC_W;
    localparam int SHIFT = REF_W + SIG_W + GUARD_W - OUT_W - FRAC_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_en = 1'b0, acc_en = 1'b0;
    logic [REF_W-1:0]   ref_dir = '0, ref_quad = '0;
    logic [SIG_W-1:0]   sig_in = '0;
    logic [4*OUT_W-1:0] integrals;

    int n_run = 0, n_fail = 0;
    longint model [4];
    int     mphase = 0;
    bit     done = 0;

    always #2.5 clk = ~clk;

    iq_fourier_acc #(.REF_W(REF_W), .SIG_W(SIG_W), .OUT_W(OUT_W),
                     .GUARD_W(GUARD_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .acc_en(acc_en),
        .ref_dir(ref_dir), .ref_quad(ref_quad), .sig_in(sig_in),
        .integrals(integrals));

    // R6: floor shift of the signed product, width ACC_W
    function automatic longint scale_prod(input logic [REF_W-1:0] r,
                                          input logic [SIG_W-1:0] s);
        longint p;
        p = longint'($signed(r)) * longint'($signed(s));
        return p >>> SHIFT;
    endfunction

    // R7: field k of the expected output
    function automatic longint exp_field(input int k);
        return (model[k] >> FRAC_W) & ((64'd1 << OUT_W) - 1);
    endfunction

    task automatic check_all(input string req);
        for (int k = 0; k < 4; k++) begin
            longint act;
            act = longint'(integrals[k*OUT_W +: OUT_W]);
            n_run++;
            if (act != exp_field(k)) begin
                n_fail++;
                $display("FAIL %s field %0d: actual %0h expected %0h", req, k, act, exp_field(k));
            end
        end
    endtask

    // One clock: drive at negedge, update the model at the edge, compare at next negedge.
    task automatic cyc(input bit rn, input bit se, input bit ae,
                       input logic [REF_W-1:0] a, input logic [REF_W-1:0] b,
                       input logic [SIG_W-1:0] s, input string req);
        rst_n = rn; step_en = se; acc_en = ae;
        ref_dir = a; ref_quad = b; sig_in = s;
        @(posedge clk);
        if (!rn) begin
            for (int k = 0; k < 4; k++) model[k] = 0;
            mphase = 0;
        end else begin
            if (se && ae) begin
                int q;
                q = mphase % 2;
                model[q]     = (model[q]     + scale_prod(a, s)) & ((64'd1 << ACC_W) - 1);
                model[2 + q] = (model[2 + q] + scale_prod(b, s)) & ((64'd1 << ACC_W) - 1);
            end
            if (se) mphase = (mphase + 1) % 4;
        end
        @(negedge clk);
        check_all(req);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'h5EED_1A2B));
        @(negedge clk);
        // R1: reset with busy inputs clears everything
        cyc(0, 1, 1, 11'h3FF, 11'h155, 16'h7FFF, "R1");
        cyc(0, 1, 1, 11'h3FF, 11'h155, 16'h7FFF, "R1");
        // R2/R5: one full group, distinct samples per phase
        cyc(1, 1, 1, 11'd100, 11'd300, 16'd20000, "R2");
        cyc(1, 1, 1, 11'd200, -11'sd50, 16'd15000, "R2");
        cyc(1, 1, 1, -11'sd100, -11'sd300, -16'sd20000, "R5");
        cyc(1, 1, 1, -11'sd200, 11'sd50, -16'sd15000, "R5");
        // R3: accumulate without step is ignored, phase stays
        cyc(1, 0, 1, 11'h3FF, 11'h3FF, 16'h7FFF, "R3");
        cyc(1, 1, 1, 11'd500, 11'd0, 16'd30000, "R3");   // lands on I if phase held
        // R4: step without accumulate moves phase only
        cyc(1, 1, 0, 11'h3FF, 11'h3FF, 16'h7FFF, "R4");
        cyc(1, 1, 1, 11'd0, 11'd400, 16'd30000, "R4");   // lands on -I
        cyc(1, 1, 1, 11'd1, 11'd1, 16'd1, "R4");
        // R1: mid-run reset, then first sample goes to I
        cyc(0, 1, 1, 11'd7, 11'd7, 16'd7, "R1");
        cyc(1, 1, 1, 11'd1000, 11'd0, 16'd32767, "R1");
        cyc(1, 1, 0, 11'd0, 11'd0, 16'd0, "R1");
        cyc(1, 1, 0, 11'd0, 11'd0, 16'd0, "R1");
        cyc(1, 1, 0, 11'd0, 11'd0, 16'd0, "R1");
        // R6: floor rounding of a tiny negative product
        cyc(1, 1, 1, -11'sd1, 11'd1, 16'd1, "R6");
        // R6: wrap with extreme negative-by-negative products
        for (int i = 0; i < 600; i++)
            cyc(1, 1, 1, 11'h400, 11'h400, 16'h8000, "R6");
        // R7: only direct-Q driven
        cyc(0, 0, 0, 0, 0, 0, "R7");
        cyc(1, 1, 0, 0, 0, 0, "R7");
        cyc(1, 1, 1, 11'd700, 11'd0, 16'd25000, "R7");
        // R8: paired accumulate pulses with zero gap and random gaps
        for (int i = 0; i < 3000; i++) begin
            bit se, ae;
            se = ($urandom % 4) != 0;
            ae = (i % 4 == 0 || i % 4 == 1) ? 1'b1 : (($urandom % 3) == 0);
            cyc(1, se, ae, REF_W'($urandom), REF_W'($urandom), SIG_W'($urandom), "R8");
        end
        report();
    end
endmodule